// File: doc/BRIEF.md
# Dual Input-Capture Timer

A 32-bit counting timer with one compare channel and two edge-selectable capture channels, reached through a small synchronous register port. A prescaler divides the clock into count ticks while the timer is enabled. The compare channel flags the tick on which the counter equals the compare value. Depending on the free-run control bit, the counter then either keeps counting or restarts from zero.

Each capture pin is asynchronous to the block clock. A pin passes through a two-flop synchronizer and then into a small edge state machine per channel. The states are `EDG_OFF` (mode is off), `EDG_LOW` (the synchronized pin is low) and `EDG_HIGH` (the synchronized pin is high). The transitions are:

- `EDG_OFF` to `EDG_LOW` or `EDG_HIGH` when a mode is selected. The target state follows the current level, and this transition never produces an event.
- `EDG_LOW` to `EDG_HIGH` on a rise. This is an event in rising or both-edge mode.
- `EDG_HIGH` to `EDG_LOW` on a fall. This is an event in falling or both-edge mode.
- Any state back to `EDG_OFF` when the mode is set to off.

The run control is a second state machine with the states `TMR_STOP` and `TMR_RUN`. It enters `TMR_RUN` when the enable bit is set and returns to `TMR_STOP` when the bit is cleared. The prescaler counts only in `TMR_RUN`.

When a capture event occurs, the current counter value is latched and a status bit is raised. All three event sources share one status register and one interrupt-enable register. Status bits are acknowledged individually by writing ones. A single registered interrupt line reports any enabled pending source. Software then reads the status register to tell which source fired.

Top module: `dcap_timer`

## Requirements
- R1: Register offsets:

  | Offset | Register |
  |---|---|
  | 0x00 | Control |
  | 0x04 | Prescaler |
  | 0x08 | Status |
  | 0x0C | Interrupt enable |
  | 0x10 | Compare |
  | 0x1C | Capture 1 |
  | 0x20 | Capture 2 |
  | 0x24 | Counter |

  Read data appears on `reg_rdata` one clock after the address is presented. After reset, every register reads 0 except compare, which reads all ones, and `reg_rdata` and `irq` are 0.
- R2: Control bit 0 enables counting. While it is clear, the counter holds its value. Writes to the counter offset are ignored.
- R3: With prescaler value P, the counter advances once every P+1 enabled clock cycles. The prescaler phase restarts whenever the timer stops.
- R4: A tick taken while the counter equals compare sets status bit 0. With control bit 9 set, the counter then continues to compare+1. With bit 9 clear, the next counter value is 0.
- R5: The capture mode fields sit at control bits 17:16 (channel 1) and 19:18 (channel 2), encoded as follows:

  | Code | Mode |
  |---|---|
  | 0 | off |
  | 1 | rising edge |
  | 2 | falling edge |
  | 3 | both edges |

  Edges that do not match the mode are ignored. Turning a mode on while the pin is high produces no event.
- R6: A capture event on channel 1 or 2 latches the counter into the capture 1 or capture 2 register and sets status bit 3 or 4. A later event overwrites the value even while the bit is pending.
- R7: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R8: The interrupt-enable register uses the status bit positions (0, 3, 4). `irq` is the registered OR of status AND enable over those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| cap_pin_a | input | 1 | Asynchronous capture input, channel 1 |
| cap_pin_b | input | 1 | Asynchronous capture input, channel 2 |
| irq | output | 1 | Combined interrupt request |

## Verification
An edge state machine left in the wrong level state shows as a missing or spurious status bit within three clocks of a pin change. It then shows on `irq` one clock after that. A prescaler or run-state fault shows in the counter value read back after a timed run, because the expected tick count is exact for a known write spacing. A broken restart or free-run path shows as a counter that is off by compare+1 after a run that crosses the compare value. A broken acknowledge path shows as status bits that survive, or vanish with, the wrong write pattern.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
    typedef enum logic [0:0] {TMR_STOP, TMR_RUN} tmr_state_e;
    typedef enum logic [1:0] {EDG_OFF, EDG_LOW, EDG_HIGH} edg_state_e;
    typedef enum logic [1:0] {CAPM_OFF = 2'd0, CAPM_RISE = 2'd1,
                              CAPM_FALL = 2'd2, CAPM_BOTH = 2'd3} capm_e;

    localparam int unsigned OFS_CTRL     = 'h00;
    localparam int unsigned OFS_PRE      = 'h04;
    localparam int unsigned OFS_STAT     = 'h08;
    localparam int unsigned OFS_IE       = 'h0C;
    localparam int unsigned OFS_CMP      = 'h10;
    localparam int unsigned OFS_CAP_BASE = 'h1C;
    localparam int unsigned CAP_STRIDE   = 4;
    localparam int unsigned OFS_CNT      = 'h24;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_FRR_BIT = 9;
    localparam int unsigned CTRL_M_LSB   = 16;
    localparam int unsigned ST_CMP_BIT   = 0;
    localparam int unsigned ST_CAP_LSB   = 3;
endpackage

// File: rtl/dcap_tick_gen.sv
module dcap_tick_gen
    import dcap_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] pre_div,
    output logic             tick
);
    tmr_state_e       state_q, state_d;
    logic [PRE_W-1:0] phase_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_STOP: if (enable)  state_d = TMR_RUN;
            TMR_RUN:  if (!enable) state_d = TMR_STOP;
            default:  state_d = TMR_STOP;
        endcase
    end

    // outputs
    always_comb begin
        tick = (state_q == TMR_RUN) && (phase_q >= pre_div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   phase_q <= '0;
        else if (state_q != TMR_RUN)  phase_q <= '0;
        else if (phase_q >= pre_div)  phase_q <= '0;
        else                          phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/dcap_counter.sv
module dcap_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             free_run,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        match = tick && (cnt_q == cmp_val);
        cnt   = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (match && !free_run) cnt_q <= '0;
        else if (tick)           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dcap_edge_fsm.sv
module dcap_edge_fsm
    import dcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_async,
    input  logic [1:0] mode,
    output logic       evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    edg_state_e             state_q, state_d;
    logic                   mode_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
    end

    assign lvl     = sync_q[SYNC_STAGES-1];
    assign mode_on = (mode != CAPM_OFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDG_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_OFF:  if (mode_on) state_d = lvl ? EDG_HIGH : EDG_LOW;
            EDG_LOW:  if (!mode_on) state_d = EDG_OFF;
                      else if (lvl) state_d = EDG_HIGH;
            EDG_HIGH: if (!mode_on) state_d = EDG_OFF;
                      else if (!lvl) state_d = EDG_LOW;
            default:  state_d = EDG_OFF;
        endcase
    end

    // outputs
    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            EDG_LOW:  evt = lvl  && (mode == CAPM_RISE || mode == CAPM_BOTH);
            EDG_HIGH: evt = !lvl && (mode == CAPM_FALL || mode == CAPM_BOTH);
            default:  evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/dcap_timer.sv
module dcap_timer
    import dcap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int PRE_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cap_pin_a,
    input  logic              cap_pin_b,
    output logic              irq
);
    localparam int NCAP = 2;

    logic                       en_q, frr_q;
    logic [NCAP-1:0][1:0]       mode_q;
    logic [PRE_W-1:0]           pre_q;
    logic [CNT_W-1:0]           cmp_q;
    logic [NCAP-1:0][CNT_W-1:0] cap_q;
    logic                       stat_cmp_q, ie_cmp_q;
    logic [NCAP-1:0]            stat_cap_q, ie_cap_q;
    logic [DATA_W-1:0]          rdata_q, rd_mux;
    logic                       irq_q;

    logic             tick, match;
    logic [CNT_W-1:0] cnt;
    logic [NCAP-1:0]  pins, cap_evt;
    logic             wr_ctrl, wr_pre, wr_stat, wr_ie, wr_cmp;
    logic             unused_wdata_bits;

    assign pins    = {cap_pin_b, cap_pin_a};
    assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
    assign wr_pre  = reg_we && (reg_addr == ADDR_W'(OFS_PRE));
    assign wr_stat = reg_we && (reg_addr == ADDR_W'(OFS_STAT));
    assign wr_ie   = reg_we && (reg_addr == ADDR_W'(OFS_IE));
    assign wr_cmp  = reg_we && (reg_addr == ADDR_W'(OFS_CMP));
    assign unused_wdata_bits = ^reg_wdata;

    dcap_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (en_q),
        .pre_div (pre_q),
        .tick    (tick)
    );

    dcap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmp_val  (cmp_q),
        .free_run (frr_q),
        .cnt      (cnt),
        .match    (match)
    );

    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        dcap_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pins[g]),
            .mode      (mode_q[g]),
            .evt       (cap_evt[g])
        );
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            frr_q    <= 1'b0;
            mode_q   <= '0;
            pre_q    <= '0;
            cmp_q    <= '1;
            ie_cmp_q <= 1'b0;
            ie_cap_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= reg_wdata[CTRL_EN_BIT];
                frr_q <= reg_wdata[CTRL_FRR_BIT];
                for (int i = 0; i < NCAP; i++)
                    mode_q[i] <= reg_wdata[CTRL_M_LSB + 2*i +: 2];
            end
            if (wr_pre) pre_q <= reg_wdata[PRE_W-1:0];
            if (wr_cmp) cmp_q <= reg_wdata[CNT_W-1:0];
            if (wr_ie) begin
                ie_cmp_q <= reg_wdata[ST_CMP_BIT];
                for (int i = 0; i < NCAP; i++)
                    ie_cap_q[i] <= reg_wdata[ST_CAP_LSB + i];
            end
        end
    end

    // capture values and status: a new event wins over an acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q      <= '0;
            stat_cmp_q <= 1'b0;
            stat_cap_q <= '0;
        end else begin
            stat_cmp_q <= match |
                          (stat_cmp_q & ~(wr_stat & reg_wdata[ST_CMP_BIT]));
            for (int i = 0; i < NCAP; i++) begin
                if (cap_evt[i]) cap_q[i] <= cnt;
                stat_cap_q[i] <= cap_evt[i] |
                                 (stat_cap_q[i] & ~(wr_stat & reg_wdata[ST_CAP_LSB + i]));
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            ADDR_W'(OFS_CTRL): begin
                rd_mux[CTRL_EN_BIT]  = en_q;
                rd_mux[CTRL_FRR_BIT] = frr_q;
                for (int i = 0; i < NCAP; i++)
                    rd_mux[CTRL_M_LSB + 2*i +: 2] = mode_q[i];
            end
            ADDR_W'(OFS_PRE):  rd_mux[PRE_W-1:0] = pre_q;
            ADDR_W'(OFS_STAT): begin
                rd_mux[ST_CMP_BIT] = stat_cmp_q;
                for (int i = 0; i < NCAP; i++) rd_mux[ST_CAP_LSB + i] = stat_cap_q[i];
            end
            ADDR_W'(OFS_IE): begin
                rd_mux[ST_CMP_BIT] = ie_cmp_q;
                for (int i = 0; i < NCAP; i++) rd_mux[ST_CAP_LSB + i] = ie_cap_q[i];
            end
            ADDR_W'(OFS_CMP):  rd_mux = DATA_W'(cmp_q);
            ADDR_W'(OFS_CNT):  rd_mux = DATA_W'(cnt);
            default: begin
                for (int i = 0; i < NCAP; i++)
                    if (reg_addr == ADDR_W'(OFS_CAP_BASE + CAP_STRIDE*i))
                        rd_mux = DATA_W'(cap_q[i]);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            rdata_q <= rd_mux;
            irq_q   <= (stat_cmp_q & ie_cmp_q) | (|(stat_cap_q & ie_cap_q));
        end
    end

    assign reg_rdata = rdata_q;
    assign irq       = irq_q;
endmodule

// File: rtl/dcap_timer_chk.sv
module dcap_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stat,
    input logic [4:0]       wdata_lo,
    input logic [1:0]       cap_evt,
    input logic [1:0]       mode_a,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap_a,
    input logic [CNT_W-1:0] cap_b,
    input logic             stat_cmp,
    input logic [1:0]       stat_cap,
    input logic             ie_cmp,
    input logic [1:0]       ie_cap,
    input logic             tick,
    input logic             match,
    input logic             frr,
    input logic             irq
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !frr) |=> (cnt == '0));
    p_freerun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && frr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    p_cmp_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> stat_cmp);
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 2'd0) |-> !cap_evt[0]);
    p_cap_a_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt[0] |=> (cap_a == $past(cnt)) && stat_cap[0]);
    p_cap_b_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt[1] |=> (cap_b == $past(cnt)) && stat_cap[1]);
    p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata_lo[3] && !cap_evt[0]) |=> !stat_cap[0]);
    p_w0_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wdata_lo[4] && stat_cap[1]) |=> stat_cap[1]);
    p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_cmp && ie_cmp) || (|(stat_cap & ie_cap))) |=> irq);
    p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((stat_cmp && ie_cmp) || (|(stat_cap & ie_cap))) |=> !irq);
endmodule

bind dcap_timer dcap_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stat  (wr_stat),
    .wdata_lo (reg_wdata[4:0]),
    .cap_evt  (cap_evt),
    .mode_a   (mode_q[0]),
    .cnt      (cnt),
    .cap_a    (cap_q[0]),
    .cap_b    (cap_q[1]),
    .stat_cmp (stat_cmp_q),
    .stat_cap (stat_cap_q),
    .ie_cmp   (ie_cmp_q),
    .ie_cap   (ie_cap_q),
    .tick     (tick),
    .match    (match),
    .frr      (frr_q),
    .irq      (irq)
);

// File: tb/dcap_timer_tb.sv
`timescale 1ns/1ps
module dcap_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_pin_a = 1'b0;
    logic        cap_pin_b = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    dcap_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_pin_a (cap_pin_a),
        .cap_pin_b (cap_pin_b),
        .irq       (irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int  n_checks = 0;
    int  n_fail   = 0;
    logic rd_fire = 1'b0;
    logic mon_arm = 1'b0;
    bit  done     = 1'b0;

    // bench model of the timer
    logic [31:0] m_cnt  = '0;
    logic [31:0] m_cmp  = '1;
    logic [31:0] m_ctrl = '0;
    int          m_pre  = 0;

    // monitor: compares read data one clock after the address was presented
    always @(posedge clk) mon_arm <= rd_fire;
    always @(negedge clk) begin
        if (mon_arm) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (reg_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        reg_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_fire = 1'b1;
        @(negedge clk);
        rd_fire = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_checks++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // enable for K idle cycles between the two control writes: K+2 run cycles
    task automatic run_timer(input int k, output bit matched);
        int ticks;
        matched = 1'b0;
        wr(8'h00, m_ctrl | 32'h1);
        idle(k);
        wr(8'h00, m_ctrl & ~32'h1);
        ticks = (k + 2) / (m_pre + 1);
        for (int t = 0; t < ticks; t++) begin
            if (m_cnt == m_cmp) begin
                matched = 1'b1;
                m_cnt = m_ctrl[9] ? m_cnt + 1 : 32'h0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not end");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit hit;
        repeat (3) @(negedge clk);
        // R1 reset state
        n_checks++;
        if (reg_rdata !== 32'h0) begin
            n_fail++; $display("FAIL R1 rdata reset: got %h expected 0", reg_rdata);
        end
        chk_irq(1'b0, "R1 irq reset");
        rst_n = 1'b1;
        idle(2);
        rd_exp(8'h00, 32'h0, "R1 ctrl reset");
        rd_exp(8'h10, 32'hFFFF_FFFF, "R1 compare reset");
        rd_exp(8'h08, 32'h0, "R1 status reset");
        rd_exp(8'h24, 32'h0, "R1 counter reset");

        // R2 counting and holding, counter writes ignored
        run_timer(10, hit);
        rd_exp(8'h24, m_cnt, "R2 counter after run");
        idle(6);
        rd_exp(8'h24, m_cnt, "R2 counter holds while disabled");
        wr(8'h24, 32'h55);
        rd_exp(8'h24, m_cnt, "R2 counter write ignored");

        // R3 prescaler
        m_pre = 3;
        wr(8'h04, 32'd3);
        rd_exp(8'h04, 32'd3, "R1 prescaler readback");
        run_timer(18, hit);
        rd_exp(8'h24, m_cnt, "R3 counter with prescaler 3");
        m_pre = 0;
        wr(8'h04, 32'd0);

        // R4 restart on compare
        m_cmp = m_cnt + 3;
        wr(8'h10, m_cmp);
        run_timer(10, hit);
        rd_exp(8'h24, m_cnt, "R4 counter after restart");
        rd_exp(8'h08, hit ? 32'h1 : 32'h0, "R4 compare flag restart");
        wr(8'h08, 32'h1);
        rd_exp(8'h08, 32'h0, "R7 compare flag acknowledged");

        // R4 free-run
        m_ctrl = 32'h200;
        m_cmp  = m_cnt + 3;
        wr(8'h10, m_cmp);
        run_timer(8, hit);
        rd_exp(8'h24, m_cnt, "R4 free-run counter");
        rd_exp(8'h08, hit ? 32'h1 : 32'h0, "R4 compare flag free-run");
        wr(8'h08, 32'h1);
        m_ctrl = 32'h0;
        m_cmp  = 32'hFFFF_FFFF;
        wr(8'h10, m_cmp);

        // R5/R6 channel 1 rising only
        m_ctrl = 32'h0001_0000;
        wr(8'h00, m_ctrl);
        cap_pin_a = 1'b1; idle(5);
        rd_exp(8'h08, 32'h08, "R6 capture 1 flag on rise");
        rd_exp(8'h1C, m_cnt, "R6 capture 1 value");
        wr(8'h08, 32'h08);
        cap_pin_a = 1'b0; idle(5);
        rd_exp(8'h08, 32'h0, "R5 falling edge ignored in rising mode");

        // R5 channel 2 falling only
        m_ctrl = 32'h0009_0000;
        wr(8'h00, m_ctrl);
        rd_exp(8'h00, m_ctrl, "R5 mode fields readback");
        cap_pin_b = 1'b1; idle(5);
        rd_exp(8'h08, 32'h0, "R5 rising edge ignored in falling mode");
        cap_pin_b = 1'b0; idle(5);
        rd_exp(8'h08, 32'h10, "R5 capture 2 on fall");
        rd_exp(8'h20, m_cnt, "R6 capture 2 value");

        // R5 enabling while pin high gives no event
        m_ctrl = 32'h0008_0000;
        wr(8'h00, m_ctrl);
        cap_pin_a = 1'b1; idle(5);
        rd_exp(8'h08, 32'h10, "R5 no event with mode off");
        m_ctrl = 32'h000B_0000;
        wr(8'h00, m_ctrl);
        idle(5);
        rd_exp(8'h08, 32'h10, "R5 enable while high no event");
        cap_pin_a = 1'b0; idle(5);
        rd_exp(8'h08, 32'h18, "R5 both-edge mode fall");
        rd_exp(8'h1C, m_cnt, "R6 capture 1 value both mode");

        // R6 overwrite while pending
        run_timer(3, hit);
        cap_pin_a = 1'b1; idle(5);
        rd_exp(8'h1C, m_cnt, "R6 overwrite while pending");
        rd_exp(8'h08, 32'h18, "R6 flag still set after overwrite");

        // R7 selective acknowledge
        wr(8'h08, 32'h08);
        rd_exp(8'h08, 32'h10, "R7 clear bit 3 only");
        wr(8'h08, 32'h00);
        rd_exp(8'h08, 32'h10, "R7 write zero keeps bits");
        wr(8'h08, 32'h01);
        rd_exp(8'h08, 32'h10, "R7 clearing other bit keeps bit 4");

        // R8 interrupt masking
        chk_irq(1'b0, "R8 irq masked");
        wr(8'h0C, 32'h10);
        idle(2);
        chk_irq(1'b1, "R8 irq on enabled pending source");
        rd_exp(8'h0C, 32'h10, "R8 enable readback");
        wr(8'h0C, 32'h09);
        idle(2);
        chk_irq(1'b0, "R8 irq off when pending source disabled");
        wr(8'h08, 32'h10);
        wr(8'h0C, 32'h19);
        idle(2);
        chk_irq(1'b0, "R8 irq off with nothing pending");
        cap_pin_b = 1'b1; idle(5);
        cap_pin_b = 1'b0; idle(5);
        chk_irq(1'b1, "R8 irq from capture 2");

        idle(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule